// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Butterfly

This block is the arithmetic core of one stage of a streaming FFT. On every clock where the enable input is high it takes two complex samples `a` and `b`, a complex twiddle coefficient `c` and a sync flag. It returns the sum `a + b` on one output and the twiddled difference `(a − b)·c` on the other. Both results are scaled and rounded to the output width. They leave together, and the sync flag travels alongside them.

All pipeline registers advance only on enabled clocks. A result therefore appears a fixed number of enabled cycles after its inputs, however many idle clocks lie between. The clocks-per-enable parameter `CKPCE` lets a slow stream share its multipliers:

- **1:** accepts data every clock and uses three real multipliers.
- **2:** needs at least one idle clock between enables and uses two.
- **3:** needs at least two idle clocks between enables and uses one.

Every complex word carries the real part in its upper half and the imaginary part in its lower half.

Top module: `r2_dif_butterfly`

## Requirements
- R1: Each component of `o_sum` equals the rounded value of the matching component of `a + b`, with the addition done at IW+1 bits so that full-scale inputs do not overflow.
- R2: `o_dif` equals the rounded value of `(a − b)·c`, where `c` is signed fixed point and 2^(CW−2) stands for 1.0. The real part is `dr·cr − di·ci` and the imaginary part is `dr·ci + di·cr`.
- R3: Every complex word (`i_a`, `i_b`, `i_coef`, `o_sum`, `o_dif`) holds the real part in bits [2W−1:W] and the imaginary part in bits [W−1:0], both two's complement.
- R4: Reduction to OW bits works as follows:
  - The sum drops DS = IW+1−OW−SHIFT low bits (DS ≥ 1).
  - The product drops DS+CW−2 low bits.
  - Rounding is to nearest, with exact halves going to the even neighbour.
  - Only the low OW bits of the rounded value are kept, so an out-of-range result wraps.
- R5: Inputs taken on enabled edge n appear on the outputs after enabled edge n+2. They are therefore valid while the enabled cycle n+3 is sampled.
- R6: On clocks with `i_en` low, `o_sum`, `o_dif` and `o_sync` keep their values.
- R7: `o_sync` is high exactly while the outputs carry the result of an input pair that had `i_sync` high, and low for every other result, including a sync in mid-stream.
- R8: While `i_rst` is high, and after it, `o_sync` is low. A sync already inside the pipeline is discarded by reset.
- R9: With CKPCE=1 the block accepts a new input pair on every clock.
- R10: With CKPCE=2, given at least one idle clock between enables, results are bit-exact, using two real multipliers.
- R11: With CKPCE=3, given at least two idle clocks between enables, results are bit-exact, using one time-shared real multiplier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous active-high reset of the sync pipeline |
| i_en | input | 1 | Enable: marks a clock that carries an input pair and advances the pipeline |
| i_sync | input | 1 | Marks the first pair of a transform |
| i_a | input | 2*IW | First complex sample |
| i_b | input | 2*IW | Second complex sample |
| i_coef | input | 2*CW | Complex twiddle coefficient |
| o_sum | output | 2*OW | Rounded a + b |
| o_dif | output | 2*OW | Rounded (a − b)·c |
| o_sync | output | 1 | Marks the result of the synced pair |

## Verification
Full-scale pairs of opposite sign test the widened difference: a design that subtracts at IW bits turns a difference of 4095 into a negative number. Odd sums and exact half-LSB products of both signs test the rounding: truncation or half-away-from-zero rounding is off by one on these codes, and one vector rounds up past full scale to test the wrap. The same vector stream is run with zero, one, two and three idle clocks between enables, with the sync placed at the start and in mid-stream. A phase mistake in the shared-multiplier variants therefore shows up as swapped or stale partial products, and a latency error shows up as a shifted sync. A sync is also caught inside the pipeline by a reset; a design that leaves it there raises `o_sync` a few enables later.

// File: rtl/r2bf_pkg.sv
package r2bf_pkg;

  // Pass selector for the single-multiplier variant.
  typedef enum logic [1:0] {
    MP_SUM_RE = 2'd0,   // c_re * (d_re + d_im)
    MP_DIM_CS = 2'd1,   // d_im * (c_re + c_im)
    MP_DRE_CD = 2'd2    // d_re * (c_im - c_re)
  } mul_pass_e;

  // Width that holds every partial product of the complex multiply.
  function automatic int prod_w(input int iw, input int cw);
    return iw + cw + 3;
  endfunction

endpackage

// File: rtl/r2bf_addsub.sv
module r2bf_addsub #(
  parameter int IW = 12
) (
  input  logic                  i_clk,
  input  logic                  i_en,
  input  logic [2*IW-1:0]       i_a,
  input  logic [2*IW-1:0]       i_b,
  output logic [2*(IW+1)-1:0]   o_sum,
  output logic [2*(IW+1)-1:0]   o_dif
);
  localparam int DW = IW + 1;

  // k = 1 is the real half, k = 0 the imaginary half
  for (genvar k = 0; k < 2; k++) begin : g_part
    logic signed [DW-1:0] a_x, b_x, sum_q, dif_q;
    assign a_x = DW'($signed(i_a[k*IW +: IW]));
    assign b_x = DW'($signed(i_b[k*IW +: IW]));
    always_ff @(posedge i_clk) begin
      if (i_en) begin
        sum_q <= a_x + b_x;
        dif_q <= a_x - b_x;
      end
    end
    assign o_sum[k*DW +: DW] = sum_q;
    assign o_dif[k*DW +: DW] = dif_q;
  end

endmodule

// File: rtl/r2bf_cmul.sv
module r2bf_cmul import r2bf_pkg::*; #(
  parameter int IW    = 12,
  parameter int CW    = 12,
  parameter int CKPCE = 1
) (
  input  logic                              i_clk,
  input  logic                              i_en,
  input  logic signed [IW:0]                i_dre,
  input  logic signed [IW:0]                i_dim,
  input  logic signed [CW-1:0]              i_cre,
  input  logic signed [CW-1:0]              i_cim,
  output logic signed [prod_w(IW,CW)-1:0]   o_pre,
  output logic signed [prod_w(IW,CW)-1:0]   o_pim
);
  localparam int PW = prod_w(IW, CW);

  logic signed [PW-1:0] pre_nx, pim_nx;

  // Result register: captured on the enabled edge after the operands.
  always_ff @(posedge i_clk) begin
    if (i_en) begin
      o_pre <= pre_nx;
      o_pim <= pim_nx;
    end
  end

  if (CKPCE == 1) begin : g_three_mul
    logic signed [PW-1:0] dre_w, dim_w, dsum_w, cre_w, cim_w, csum_w, cdif_w;
    logic signed [PW-1:0] t1, t2, t3;
    assign dre_w  = PW'(i_dre);
    assign dim_w  = PW'(i_dim);
    assign cre_w  = PW'(i_cre);
    assign cim_w  = PW'(i_cim);
    assign dsum_w = dre_w + dim_w;
    assign csum_w = cre_w + cim_w;
    assign cdif_w = cim_w - cre_w;
    assign t1 = cre_w * dsum_w;
    assign t2 = dim_w * csum_w;
    assign t3 = dre_w * cdif_w;
    assign pre_nx = t1 - t2;
    assign pim_nx = t1 + t3;
  end else if (CKPCE == 2) begin : g_two_mul
    logic                 ph_q;      // high on the clock right after an enable
    logic signed [PW-1:0] dre_w, dim_w, cre_w, cim_w, m0, m1, pa_q;
    assign dre_w = PW'(i_dre);
    assign dim_w = PW'(i_dim);
    assign cre_w = PW'(i_cre);
    assign cim_w = PW'(i_cim);
    always_ff @(posedge i_clk) ph_q <= i_en;
    // first clock: real products; following clock: cross products
    assign m0 = dre_w * (ph_q ? cre_w : cim_w);
    assign m1 = dim_w * (ph_q ? cim_w : cre_w);
    always_ff @(posedge i_clk) begin
      if (ph_q) pa_q <= m0 - m1;
    end
    assign pre_nx = pa_q;
    assign pim_nx = m0 + m1;
  end else begin : g_one_mul
    mul_pass_e            pass_q;
    logic signed [PW-1:0] dre_w, dim_w, dsum_w, cre_w, cim_w, csum_w, cdif_w;
    logic signed [PW-1:0] x_m, y_m, m, t1_q, t2_q;
    assign dre_w  = PW'(i_dre);
    assign dim_w  = PW'(i_dim);
    assign cre_w  = PW'(i_cre);
    assign cim_w  = PW'(i_cim);
    assign dsum_w = dre_w + dim_w;
    assign csum_w = cre_w + cim_w;
    assign cdif_w = cim_w - cre_w;

    always_ff @(posedge i_clk) begin
      if (i_en) pass_q <= MP_SUM_RE;
      else begin
        case (pass_q)
          MP_SUM_RE: pass_q <= MP_DIM_CS;
          MP_DIM_CS: pass_q <= MP_DRE_CD;
          default:   pass_q <= MP_DRE_CD;
        endcase
      end
    end

    always_comb begin
      case (pass_q)
        MP_SUM_RE: begin x_m = dsum_w; y_m = cre_w;  end
        MP_DIM_CS: begin x_m = dim_w;  y_m = csum_w; end
        default:   begin x_m = dre_w;  y_m = cdif_w; end
      endcase
    end
    assign m = x_m * y_m;

    always_ff @(posedge i_clk) begin
      if (pass_q == MP_SUM_RE) t1_q <= m;
      if (pass_q == MP_DIM_CS) t2_q <= m;
    end
    assign pre_nx = t1_q - t2_q;
    assign pim_nx = t1_q + m;
  end

endmodule

// File: rtl/r2bf_round.sv
module r2bf_round #(
  parameter int IN_W  = 13,
  parameter int DROP  = 1,
  parameter int OUT_W = 12
) (
  input  logic signed [IN_W-1:0] i_x,
  output logic [OUT_W-1:0]       o_y
);
  localparam logic [DROP-1:0] HALF = DROP'(1) << (DROP - 1);

  logic [DROP-1:0] frac;
  logic            up;

  assign frac = i_x[DROP-1:0];
  // above half rounds up; exactly half rounds toward an even kept value
  assign up   = (frac > HALF) || ((frac == HALF) && i_x[DROP]);
  assign o_y  = OUT_W'(i_x >>> DROP) + OUT_W'(up);

endmodule

// File: rtl/r2_dif_butterfly.sv
module r2_dif_butterfly import r2bf_pkg::*; #(
  parameter int IW    = 12,
  parameter int CW    = 12,
  parameter int OW    = 12,
  parameter int SHIFT = 0,
  parameter int CKPCE = 1
) (
  input  logic            i_clk,
  input  logic            i_rst,
  input  logic            i_en,
  input  logic            i_sync,
  input  logic [2*IW-1:0] i_a,
  input  logic [2*IW-1:0] i_b,
  input  logic [2*CW-1:0] i_coef,
  output logic [2*OW-1:0] o_sum,
  output logic [2*OW-1:0] o_dif,
  output logic            o_sync
);
  localparam int DW     = IW + 1;
  localparam int PW     = prod_w(IW, CW);
  localparam int DROP_S = IW + 1 - OW - SHIFT;
  localparam int DROP_P = DROP_S + CW - 2;

  // stage 1: sum / difference, coefficient alignment
  logic [2*DW-1:0] sum_s1, dif_s1;
  logic [2*CW-1:0] coef_s1;
  logic            sync_s1, sync_s2;

  r2bf_addsub #(.IW(IW)) u_addsub (
    .i_clk (i_clk),
    .i_en  (i_en),
    .i_a   (i_a),
    .i_b   (i_b),
    .o_sum (sum_s1),
    .o_dif (dif_s1)
  );

  always_ff @(posedge i_clk) begin
    if (i_en) coef_s1 <= i_coef;
  end

  // stage 2: complex product, sum delayed to match
  logic signed [PW-1:0] prod_s2 [2];
  logic [2*DW-1:0]      sum_s2;

  r2bf_cmul #(.IW(IW), .CW(CW), .CKPCE(CKPCE)) u_cmul (
    .i_clk (i_clk),
    .i_en  (i_en),
    .i_dre (dif_s1[DW +: DW]),
    .i_dim (dif_s1[0 +: DW]),
    .i_cre (coef_s1[CW +: CW]),
    .i_cim (coef_s1[0 +: CW]),
    .o_pre (prod_s2[1]),
    .o_pim (prod_s2[0])
  );

  always_ff @(posedge i_clk) begin
    if (i_en) sum_s2 <= sum_s1;
  end

  // stage 3: rounding into the output registers
  logic [2*OW-1:0] sum_rnd, dif_rnd;

  for (genvar k = 0; k < 2; k++) begin : g_rnd
    r2bf_round #(.IN_W(DW), .DROP(DROP_S), .OUT_W(OW)) u_rnd_sum (
      .i_x (sum_s2[k*DW +: DW]),
      .o_y (sum_rnd[k*OW +: OW])
    );
    r2bf_round #(.IN_W(PW), .DROP(DROP_P), .OUT_W(OW)) u_rnd_dif (
      .i_x (prod_s2[k]),
      .o_y (dif_rnd[k*OW +: OW])
    );
  end

  always_ff @(posedge i_clk) begin
    if (i_en) begin
      o_sum <= sum_rnd;
      o_dif <= dif_rnd;
    end
  end

  // sync pipeline: the only state with a reset
  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      sync_s1 <= 1'b0;
      sync_s2 <= 1'b0;
      o_sync  <= 1'b0;
    end else if (i_en) begin
      sync_s1 <= i_sync;
      sync_s2 <= sync_s1;
      o_sync  <= sync_s2;
    end
  end

  // R6: nothing at the outputs moves on a non-enabled clock
  assert_idle_hold_R6: assert property (@(posedge i_clk) disable iff (i_rst)
    (!$past(i_rst) && !$past(i_en)) |-> ($stable(o_sum) && $stable(o_dif) && $stable(o_sync)))
    else $error("outputs changed without enable");

  // R7: a sync can only appear after an enabled edge
  assert_sync_on_enable_R7: assert property (@(posedge i_clk) disable iff (i_rst)
    $rose(o_sync) |-> $past(i_en))
    else $error("sync rose without enable");

  // R8: reset leaves the sync output low
  assert_reset_clears_sync_R8: assert property (@(posedge i_clk)
    i_rst |=> !o_sync)
    else $error("sync high after reset");

  if (CKPCE >= 2) begin : g_chk_gap1
    // R10: caller keeps one idle clock after every enable
    assert_enable_gap_R10: assert property (@(posedge i_clk) disable iff (i_rst)
      i_en |=> !i_en)
      else $error("enable spacing below one idle clock");
  end
  if (CKPCE >= 3) begin : g_chk_gap2
    // R11: caller keeps two idle clocks after every enable
    assert_enable_gap_R11: assert property (@(posedge i_clk) disable iff (i_rst)
      i_en |-> ##2 !i_en)
      else $error("enable spacing below two idle clocks");
  end

endmodule

// File: tb/r2_dif_butterfly_tb_top.sv
`timescale 1ns/1ps
module r2_dif_butterfly_tb_top;
  localparam int IW = 12, CW = 12, OW = 12, SH = 0;
  localparam int DS = IW + 1 - OW - SH;
  localparam int DP = DS + CW - 2;
  localparam int NV = 13;

  // {a_re, a_im, b_re, b_im, c_re, c_im}; 1024 is coefficient 1.0
  localparam int VT [NV][6] = '{
    '{  100, -200,    50,    25,  1024,     0},
    '{    2,    3,     1,     0,  1024,     0},   // odd sums and half-LSB ties
    '{   -1,   -3,     0,     0,  1024,     0},   // negative ties
    '{ 2047, 2047, -2048, -2048,  1024,     0},   // widest difference, wraps
    '{ 2047, 2047,  2047,  2047, -1024,     0},   // largest sum
    '{-2048,-2048, -2048, -2048,     0, -1024},   // smallest sum
    '{  300, -700,  -900,   400,     0, -1024},
    '{ 1234, -567,   -89,  1000,   724,  -724},
    '{-1500, 1600,  1700, -1800,  -886,  -512},
    '{  511, -511,  -512,   512,  1023,  1023},
    '{    7,   -7,     3,     9, -1024,     0},
    '{    0,    0,     0,     0,  1024,     0},
    '{    5,   -3,     2,     4, -2048, -2048}    // most negative coefficient
  };

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, sync = 1'b0;
  logic [2*IW-1:0] a = '0, b = '0;
  logic [2*CW-1:0] c = '0;
  int   gap_q = 0;
  logic en2, en3;
  logic [2*OW-1:0] s1, d1, s2, d2, s3, d3;
  logic y1, y2, y3;
  int   nchk = 0, nbad = 0;

  assign en2 = en && (gap_q >= 1);
  assign en3 = en && (gap_q >= 2);

  always #2 clk = ~clk;

  r2_dif_butterfly #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SH), .CKPCE(1)) dut_i (
    .i_clk(clk), .i_rst(rst), .i_en(en), .i_sync(sync), .i_a(a), .i_b(b),
    .i_coef(c), .o_sum(s1), .o_dif(d1), .o_sync(y1));
  r2_dif_butterfly #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SH), .CKPCE(2)) dut_c2_i (
    .i_clk(clk), .i_rst(rst), .i_en(en2), .i_sync(sync), .i_a(a), .i_b(b),
    .i_coef(c), .o_sum(s2), .o_dif(d2), .o_sync(y2));
  r2_dif_butterfly #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SH), .CKPCE(3)) dut_c3_i (
    .i_clk(clk), .i_rst(rst), .i_en(en3), .i_sync(sync), .i_a(a), .i_b(b),
    .i_coef(c), .o_sum(s3), .o_dif(d3), .o_sync(y3));

  // R4 reference: drop bits, round half to even, keep the low OW bits
  function automatic logic [OW-1:0] rnd(input longint x, input int drop);
    longint keep, fr, half;
    keep = x >>> drop;
    fr   = x - (keep <<< drop);
    half = longint'(1) <<< (drop - 1);
    if (fr > half || (fr == half && keep[0])) keep = keep + 1;
    return keep[OW-1:0];
  endfunction

  // R1 R2 R3 reference: {sum_re, sum_im, dif_re, dif_im}
  function automatic logic [4*OW-1:0] model(input int i);
    longint ar, ai, br, bi, cr, ci, dr, di;
    ar = VT[i][0]; ai = VT[i][1]; br = VT[i][2];
    bi = VT[i][3]; cr = VT[i][4]; ci = VT[i][5];
    dr = ar - br; di = ai - bi;
    return {rnd(ar + br, DS), rnd(ai + bi, DS),
            rnd(dr * cr - di * ci, DP), rnd(dr * ci + di * cr, DP)};
  endfunction

  task automatic cmp(input string req, input logic [4*OW-1:0] act,
                     input logic [4*OW-1:0] exp, input logic as, input logic es);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s data act=%h exp=%h", req, act, exp);
    end
    nchk++;
    if (as !== es) begin
      nbad++;
      $display("FAIL %s sync act=%b exp=%b", req, as, es);
    end
  endtask

  task automatic load(input int i, input logic sy);
    a    = {IW'(VT[i][0]), IW'(VT[i][1])};
    b    = {IW'(VT[i][2]), IW'(VT[i][3])};
    c    = {CW'(VT[i][4]), CW'(VT[i][5])};
    sync = sy;
  endtask

  // Whole table with 'gap' idle clocks per enable; result k-3 is checked
  // while enabled slot k is set up (R5 latency).
  task automatic run_stream(input int gap, input int sync_at);
    logic [4*OW-1:0] exp, hold;
    logic            hold_y;
    gap_q = gap;
    for (int k = 0; k < NV + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        exp = model(k - 3);
        cmp($sformatf("R1 R2 R3 R4 R5 R7 R9 gap=%0d item=%0d", gap, k - 3),
            {s1, d1}, exp, y1, (k - 3) == sync_at);
        if (gap >= 1)
          cmp($sformatf("R10 R1 R2 R4 R7 gap=%0d item=%0d", gap, k - 3),
              {s2, d2}, exp, y2, (k - 3) == sync_at);
        if (gap >= 2)
          cmp($sformatf("R11 R1 R2 R4 R7 gap=%0d item=%0d", gap, k - 3),
              {s3, d3}, exp, y3, (k - 3) == sync_at);
      end
      en = 1'b1;
      if (k < NV) load(k, k == sync_at);
      else begin a = '0; b = '0; c = '0; sync = 1'b0; end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        en = 1'b0;
        if (g == 0) begin
          hold = {s1, d1}; hold_y = y1;
        end else begin
          cmp($sformatf("R6 hold gap=%0d slot=%0d", gap, k), {s1, d1}, hold, y1, hold_y);
        end
      end
    end
    @(negedge clk);
    en = 1'b0; sync = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    // R8: reset state of the sync output
    repeat (4) @(negedge clk);
    cmp("R8 in reset dut_i", '0, '0, y1, 1'b0);
    cmp("R8 in reset dut_c2_i", '0, '0, y2, 1'b0);
    cmp("R8 in reset dut_c3_i", '0, '0, y3, 1'b0);
    rst = 1'b0;

    run_stream(0, 0);   // R9 back to back
    run_stream(1, 2);   // R10 with sync in mid-stream
    run_stream(2, 0);   // R11
    run_stream(3, 5);

    // R8: a sync caught in the pipeline by reset must never come out
    gap_q = 2;
    @(negedge clk); en = 1'b1; load(0, 1'b1);
    @(negedge clk); en = 1'b0; sync = 1'b0;
    @(negedge clk);
    @(negedge clk); en = 1'b1; load(1, 1'b0);
    @(negedge clk); en = 1'b0; rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cmp($sformatf("R8 flushed sync dut_i slot=%0d", k), '0, '0, y1, 1'b0);
      cmp($sformatf("R8 flushed sync dut_c2_i slot=%0d", k), '0, '0, y2, 1'b0);
      cmp($sformatf("R8 flushed sync dut_c3_i slot=%0d", k), '0, '0, y3, 1'b0);
      en = 1'b1; load(k + 2, 1'b0);
      @(negedge clk); en = 1'b0;
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule